// File: doc/BRIEF.md
# Dual-Port Synchronous RAM With Active-Low Controls

This block is a storage array that two agents can use at the same time through two complete access ports, A and B. Each port has an active-low select, an active-low write strobe, an address, write data and read data. A port reads when its select is low and its write strobe is high. It writes when both are low. Both ports run on one clock. The address width is the base-2 logarithm of the number of words, so `ADDR_W = $clog2(DEPTH)`.

Every port input is captured in a register on a rising edge. The array is accessed on the next rising edge, which also loads the read-data register. A request presented before edge k therefore shows its read result after edge k+1. The two ports may read or write any locations in the same access cycle. A write by both ports to one word in the same access cycle is illegal. It raises a registered flag for one cycle, and port A's data is kept. When a port reads a word that the other port writes in the same cycle, it returns the contents from before the write.

Top module: `dpram_ab`

## Requirements
- R1: A read request (select 0, write strobe 1) presented before rising edge k shows the addressed word on that port's read-data output after edge k+1.
- R2: A write request (select 0, write strobe 0) stores the write data at the port's address, and a later read of that address from either port returns it.
- R3: Both ports can read in the same cycle, at different addresses or at the same address, and each returns its own addressed word.
- R4: Both ports can write different addresses in the same cycle. Both words are stored and the collision flag stays 0.
- R5: When both ports write the same address in one cycle, the collision flag is 1 for exactly one cycle, after the same edge on which read data for that cycle would appear. The word stored is port A's data.
- R6: While a port's select is 1, its read-data output keeps its previous value and the array is not written from that port, whatever its write strobe, address and data are.
- R7: A write leaves the writing port's read-data output unchanged.
- R8: A read on one port of the address the other port writes in the same cycle returns the word stored before that write.
- R9: Reset is synchronous and active-low. It clears both read-data outputs and the collision flag to 0. A request present while reset is low has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| a_csn | input | 1 | Port A select, active low |
| a_wen | input | 1 | Port A write strobe, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | WIDTH | Port A write data |
| a_q | output | WIDTH | Port A registered read data |
| b_csn | input | 1 | Port B select, active low |
| b_wen | input | 1 | Port B write strobe, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | WIDTH | Port B write data |
| b_q | output | WIDTH | Port B registered read data |
| clash_o | output | 1 | Same-address double write seen in the previous access cycle |

## Verification
On every cycle the assertions check that the collision flag follows exactly the registered same-address double writes, rising for such a cycle and staying low otherwise. They also check that a port which did not read in the access cycle keeps its output stable. The contents of the array can only be shown by the bench scenarios. These cover that the data read back is correct, that port A wins a collision, that a port reading a word the other port is writing gets the old value, and that a request made during reset is dropped. The bench runs a 16-word by 8-bit configuration with sweeps over every address, and it computes every expected word arithmetically.

// File: rtl/dpram_pkg.sv
// Package: shared types for the dual-port RAM.
// Assumes: port controls are active low; select high means no access.
package dpram_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Turn the active-low select and write strobe into an access kind.
    function automatic acc_e decode_acc(input logic csn, input logic wen);
        if (csn)
            return ACC_IDLE;
        else if (wen)
            return ACC_READ;
        else
            return ACC_WRITE;
    endfunction

endpackage

// File: rtl/dpram_port_in.sv
// Module: input register stage of one port.
// Captures the port request on each rising edge and decodes it into an
// access kind. Reset forces an idle request, so nothing present while
// rst_n is low reaches the array.
module dpram_port_in
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WIDTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  din_i,
    output acc_e              acc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WIDTH-1:0]  din_o
);

    // Register the decoded request, address and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o  <= ACC_IDLE;
            addr_o <= '0;
            din_o  <= '0;
        end else begin
            acc_o  <= decode_acc(csn_i, wen_i);
            addr_o <= addr_i;
            din_o  <= din_i;
        end
    end

endmodule

// File: rtl/dpram_array.sv
// Module: storage array with two write ports and two read paths.
// Read paths are combinational from the array. A same-edge write is not
// yet visible on them, which gives read-before-write to the output
// registers. When both ports write one word, port B's write is
// suppressed and port A's data is kept. The contents are not reset.
module dpram_array
    import dpram_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  acc_e              acc_a,
    input  acc_e              acc_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [WIDTH-1:0]  din_a,
    input  logic [WIDTH-1:0]  din_b,
    output logic [WIDTH-1:0]  rdata_a,
    output logic [WIDTH-1:0]  rdata_b,
    output logic              clash_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic             wr_a;
    logic             wr_b;

    // Flag a double write to the same word in this access cycle.
    always_comb begin
        wr_a    = (acc_a == ACC_WRITE);
        wr_b    = (acc_b == ACC_WRITE);
        clash_o = wr_a && wr_b && (addr_a == addr_b);
    end

    // Perform the writes; port B yields to port A on a clash.
    always_ff @(posedge clk) begin
        if (wr_b && !clash_o)
            mem[addr_b] <= din_b;
        if (wr_a)
            mem[addr_a] <= din_a;
    end

    // Present the stored words at both addresses.
    always_comb begin
        rdata_a = mem[addr_a];
        rdata_b = mem[addr_b];
    end

endmodule

// File: rtl/dpram_port_out.sv
// Module: read-data output register of one port.
// Loads only when the port performed a read in the access cycle. It
// holds its value otherwise, both when the port is idle and when it wrote.
module dpram_port_out #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] q_o
);

    // Capture read data on a read, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (load_i)
            q_o <= data_i;
    end

endmodule

// File: rtl/dpram_ab.sv
// Module: dual-port RAM top with active-low port controls.
// Two identical port front ends register their requests. The shared array
// serves both in the following cycle, and each port's output register
// loads the read result. Assumes one clock for both ports and a
// synchronous active-low reset.
module dpram_ab
    import dpram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_csn,
    input  logic              a_wen,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WIDTH-1:0]  a_din,
    output logic [WIDTH-1:0]  a_q,
    input  logic              b_csn,
    input  logic              b_wen,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WIDTH-1:0]  b_din,
    output logic [WIDTH-1:0]  b_q,
    output logic              clash_o
);

    localparam int NPORT = 2;

    logic [NPORT-1:0]             csn_v;
    logic [NPORT-1:0]             wen_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][WIDTH-1:0]  din_v;
    acc_e                         acc_v [NPORT];
    logic [NPORT-1:0][ADDR_W-1:0] rq_addr;
    logic [NPORT-1:0][WIDTH-1:0]  rq_din;
    logic [NPORT-1:0][WIDTH-1:0]  rdata_v;
    logic [NPORT-1:0][WIDTH-1:0]  q_v;
    logic [NPORT-1:0]             rq_rd;
    logic [NPORT-1:0]             rq_wr;
    logic                         clash_w;
    logic                         clash_q;

    // Gather the two port interfaces into indexed vectors.
    always_comb begin
        csn_v  = {b_csn, a_csn};
        wen_v  = {b_wen, a_wen};
        addr_v = {b_addr, a_addr};
        din_v  = {b_din, a_din};
        a_q    = q_v[0];
        b_q    = q_v[1];
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpram_port_in #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_in (
            .clk    (clk),
            .rst_n  (rst_n),
            .csn_i  (csn_v[p]),
            .wen_i  (wen_v[p]),
            .addr_i (addr_v[p]),
            .din_i  (din_v[p]),
            .acc_o  (acc_v[p]),
            .addr_o (rq_addr[p]),
            .din_o  (rq_din[p])
        );

        // Expose the registered access kind as read and write strobes.
        always_comb begin
            rq_rd[p] = (acc_v[p] == ACC_READ);
            rq_wr[p] = (acc_v[p] == ACC_WRITE);
        end

        dpram_port_out #(.WIDTH(WIDTH)) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (rq_rd[p]),
            .data_i (rdata_v[p]),
            .q_o    (q_v[p])
        );
    end

    dpram_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .acc_a   (acc_v[0]),
        .acc_b   (acc_v[1]),
        .addr_a  (rq_addr[0]),
        .addr_b  (rq_addr[1]),
        .din_a   (rq_din[0]),
        .din_b   (rq_din[1]),
        .rdata_a (rdata_v[0]),
        .rdata_b (rdata_v[1]),
        .clash_o (clash_w)
    );

    // Register the clash so it lines up with the read-data outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clash_q <= 1'b0;
        else
            clash_q <= clash_w;
    end

    assign clash_o = clash_q;

endmodule

// File: rtl/dpram_ab_chk.sv
// Module: assertion checker for dpram_ab, attached with bind.
// Observes the registered requests and the top-level outputs.
module dpram_ab_chk #(
    parameter int ADDR_W = 6,
    parameter int WIDTH  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             rd,
    input logic [1:0]             wr,
    input logic [1:0][ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]       a_q,
    input logic [WIDTH-1:0]       b_q,
    input logic                   clash
);

    // R5
    clash_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr[0] && wr[1] && addr[0] == addr[1]) |=> clash);

    // R5
    clash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr[0] && wr[1] && addr[0] == addr[1]) |=> !clash);

    // R6
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd[0] |=> $stable(a_q));

    // R6
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd[1] |=> $stable(b_q));

    // R7
    write_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr[0] |=> $stable(a_q));

endmodule

bind dpram_ab dpram_ab_chk #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (rq_rd),
    .wr    (rq_wr),
    .addr  (rq_addr),
    .a_q   (a_q),
    .b_q   (b_q),
    .clash (clash_o)
);

// File: tb/dpram_ab_test.sv
`timescale 1ns/1ps
module dpram_ab_test;

    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_csn = 1'b1, a_wen = 1'b1, b_csn = 1'b1, b_wen = 1'b1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [WIDTH-1:0] a_din = '0, b_din = '0;
    logic [WIDTH-1:0] a_q, b_q;
    logic clash_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [WIDTH-1:0] model [DEPTH];

    always #4 clk = ~clk;

    dpram_ab #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_csn(a_csn), .a_wen(a_wen), .a_addr(a_addr), .a_din(a_din), .a_q(a_q),
        .b_csn(b_csn), .b_wen(b_wen), .b_addr(b_addr), .b_din(b_din), .b_q(b_q),
        .clash_o(clash_o)
    );

    function automatic logic [WIDTH-1:0] pat(input int i, input int k);
        return WIDTH'((i * 37 + k * 11 + 5) & 8'hFF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic acs, input logic awe, input int aad, input logic [WIDTH-1:0] ad,
                         input logic bcs, input logic bwe, input int bad, input logic [WIDTH-1:0] bd);
        a_csn = acs; a_wen = awe; a_addr = AW'(aad); a_din = ad;
        b_csn = bcs; b_wen = bwe; b_addr = AW'(bad); b_din = bd;
    endtask

    task automatic idle();
        a_csn = 1'b1; a_wen = 1'b1; b_csn = 1'b1; b_wen = 1'b1;
    endtask

    // Present one request at a falling edge and return two falling edges later,
    // after the input register edge and the access edge.
    task automatic issue(input logic acs, input logic awe, input int aad, input logic [WIDTH-1:0] ad,
                         input logic bcs, input logic bwe, input int bad, input logic [WIDTH-1:0] bd);
        drive(acs, awe, aad, ad, bcs, bwe, bad, bd);
        @(negedge clk);
        idle();
        @(negedge clk);
    endtask

    initial begin
        logic [WIDTH-1:0] qa, qb;
        idle();
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 a_q reset", a_q, 0);
        check("R9 b_q reset", b_q, 0);
        check("R9 clash reset", clash_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R2: fill, A even words and B odd words in the same cycle
        for (int i = 0; i < DEPTH / 2; i++) begin
            issue(0, 0, 2*i, pat(2*i, 0), 0, 0, 2*i+1, pat(2*i+1, 0));
            model[2*i] = pat(2*i, 0);
            model[2*i+1] = pat(2*i+1, 0);
            check("R4 no clash on distinct writes", clash_o, 0);
        end

        // R1 / R3: dual reads at different and at equal addresses
        for (int i = 0; i < DEPTH; i++) begin
            issue(0, 1, i, 8'h00, 0, 1, DEPTH-1-i, 8'h00);
            check("R1 A read", a_q, model[i]);
            check("R3 B read other address", b_q, model[DEPTH-1-i]);
            issue(0, 1, i, 8'h00, 0, 1, i, 8'h00);
            check("R3 A same address", a_q, model[i]);
            check("R3 B same address", b_q, model[i]);
        end

        // R6: deselected ports hold outputs and do not write
        for (int i = 0; i < DEPTH; i += 3) begin
            qa = a_q; qb = b_q;
            issue(1, 0, i, 8'hEE, 1, 0, DEPTH-1-i, 8'hDD);
            check("R6 A holds when deselected", a_q, qa);
            check("R6 B holds when deselected", b_q, qb);
            issue(0, 1, i, 8'h00, 0, 1, DEPTH-1-i, 8'h00);
            check("R6 no write from deselected A", a_q, model[i]);
            check("R6 no write from deselected B", b_q, model[DEPTH-1-i]);
        end

        // R7 / R2: writing port output unchanged, then read back from other port
        for (int i = 0; i < DEPTH; i++) begin
            qa = a_q;
            issue(0, 0, i, pat(i, 1), 1, 1, 0, 8'h00);
            model[i] = pat(i, 1);
            check("R7 A output unchanged by its write", a_q, qa);
            issue(1, 1, 0, 8'h00, 0, 1, i, 8'h00);
            check("R2 write then read from B", b_q, model[i]);
        end

        // R8: read-before-write across ports, both directions
        for (int i = 0; i < DEPTH; i++) begin
            issue(0, 0, i, pat(i, 2), 0, 1, i, 8'h00);
            check("R8 B reads old word", b_q, model[i]);
            model[i] = pat(i, 2);
            issue(0, 1, i, 8'h00, 0, 0, i, pat(i, 3));
            check("R8 A reads old word", a_q, model[i]);
            model[i] = pat(i, 3);
        end

        // R5: same-address double write, flag one cycle, A wins
        for (int i = 0; i < DEPTH; i++) begin
            issue(0, 0, i, pat(i, 4), 0, 0, i, pat(i, 5));
            check("R5 clash raised", clash_o, 1);
            @(negedge clk);
            check("R5 clash one cycle only", clash_o, 0);
            model[i] = pat(i, 4);
            issue(0, 1, i, 8'h00, 0, 1, i, 8'h00);
            check("R5 port A data kept", a_q, model[i]);
        end

        // R9: reset during a write request drops it and clears outputs
        drive(0, 0, 3, 8'h5A, 0, 0, 9, 8'hA5);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        idle();
        @(negedge clk);
        check("R9 a_q cleared", a_q, 0);
        check("R9 b_q cleared", b_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(0, 1, 3, 8'h00, 0, 1, 9, 8'h00);
        check("R9 write in reset ignored A", a_q, model[3]);
        check("R9 write in reset ignored B", b_q, model[9]);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule